// File: doc/BRIEF.md
# Trigger Latency History Buffer with Sparse Serial Readout

This block keeps a rolling record of the hit state of every channel of a multi-channel front end. Each clock is one sample: the whole hit vector is written into one bin of a 193-bin circular store, so the store always holds the last 193 samples. When a trigger strobe arrives, the block goes back a programmed number of samples and takes the hit vector stored there, which is the sample that matches the trigger's delay. It then sends that event out on a single serial line.

The serial frame is sparse: a header with an event number and an event time, one word for each channel that was hit, in ascending channel order, and a trailer that carries a count of lost triggers. Bits leave most significant first, one per clock, with a frame-valid qualifier. A busy flag shows that a readout is under way. One further trigger can wait in a one-deep queue. Triggers beyond that are dropped and counted.

Top module: `ltb_trigger_readout`

## Requirements
- R1: While reset is high and in the first cycle after it, `sdo`, `sval` and `busy` are 0.
- R2: The write pointer starts at bin 0 after reset. It moves up by one bin every clock and wraps from bin 192 to bin 0, with one hit vector written per clock.
- R3: A trigger in cycle e with latency L reports the hit vector written in cycle e-L. L=0 acts as 1 and any L above 192 acts as 192.
- R4: Each hit channel is sent as a 9-bit word: marker bits 01, then the 7-bit channel number. Only channels whose bit was 1 are sent, in ascending channel number.
- R5: The frame opens with an 18-bit header: marker bits 10, then the 8-bit event number, then the 8-bit event time. The event time is the value, in the trigger cycle, of a sample counter that is 0 in the first cycle after reset and counts up every clock.
- R6: The event number of the first accepted trigger after reset is 0. It goes up by one, modulo 256, for each accepted trigger. Lost triggers take no number.
- R7: The frame closes with a 6-bit trailer: marker bits 11, then a 4-bit count of the triggers lost before this frame's trigger was accepted. The count saturates at 15.
- R8: Frame bits leave most significant bit first, one bit per clock. `sval` stays high without a break through a frame and is low for at least one cycle between two frames.
- R9: `busy` goes high in the cycle after an accepted trigger that found the block idle. It stays high whenever `sval` is high and drops only after the last queued frame.
- R10: A trigger that arrives during a readout while the queue is empty is accepted, and its frame follows the current one. A trigger that arrives while the queue is full is lost.
- R11: An event with no hit channels gives a 24-bit frame that holds only the header and the trailer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and serial clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | NCH | Hit bits of all channels for the current sample |
| trig | input | 1 | Trigger strobe, one cycle per trigger |
| lat | input | LAT_W | Look-back latency in samples |
| sdo | output | 1 | Serial frame data, MSB first |
| sval | output | 1 | Frame-valid qualifier for `sdo` |
| busy | output | 1 | Readout in progress or queued |

## Verification
The bench drives latencies of 0, 1, 192, 193 and 255 once the store has wrapped, so that it covers both clamps and the oldest bin. An off-by-one in the modulo read index, or a read that returns data from the same cycle, would report the wrong sample's channels. Bursts of back-to-back triggers check that exactly one trigger is queued, that later ones take no event number, and that the lost count reaches the trailer and saturates. A queue that is too deep, or one that drops the pending trigger when a frame ends, would shift every later header. Empty and fully hit events check that the channel scan ends correctly, that there is no missing or repeated channel word and that the trailer is never skipped. A trigger that lands in the same cycle as a frame's last bit checks the handover between the queue slot and a new trigger.

// File: rtl/ltb_pkg.sv
package ltb_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_SEND = 2'd2,
    S_DONE = 2'd3
  } rd_state_e;

  localparam logic [1:0] MK_HDR = 2'b10;
  localparam logic [1:0] MK_CH  = 2'b01;
  localparam logic [1:0] MK_TRL = 2'b11;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ltb_ring.sv
module ltb_ring #(
  parameter int NCH   = 128,
  parameter int DEPTH = 193,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] wr_hits,
  input  logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] rd_data,
  output logic [AW-1:0]  wptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [NCH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    store[wptr] <= wr_hits;
    rd_data     <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)               wptr <= '0;
    else if (wptr == LAST) wptr <= '0;
    else                   wptr <= wptr + 1'b1;
  end
endmodule

// File: rtl/ltb_rdaddr.sv
module ltb_rdaddr #(
  parameter int DEPTH = 193,
  parameter int LAT_W = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    wptr,
  input  logic [LAT_W-1:0] lat,
  output logic [AW-1:0]    rd_addr
);
  int leff;
  int diff;

  always_comb begin
    if (lat == '0)                leff = 1;
    else if (int'(lat) > DEPTH-1) leff = DEPTH - 1;
    else                          leff = int'(lat);
    diff = int'(wptr) - leff;
    if (diff < 0) diff = diff + DEPTH;
    rd_addr = diff[AW-1:0];
  end
endmodule

// File: rtl/ltb_scan.sv
module ltb_scan #(
  parameter int NCH  = 128,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  vec,
  output logic [CH_W-1:0] low_idx,
  output logic            any
);
  always_comb begin
    low_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (vec[i]) low_idx = CH_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/ltb_serial.sv
module ltb_serial
  import ltb_pkg::*;
#(
  parameter int NCH    = 128,
  parameter int EV_W   = 8,
  parameter int TIME_W = 8,
  parameter int LOST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [TIME_W-1:0] tstamp,
  input  logic [NCH-1:0]    rd_data,
  output logic              sdo,
  output logic              sval,
  output logic              busy
);
  localparam int CH_W  = $clog2(NCH);
  localparam int HDR_W = 2 + EV_W + TIME_W;
  localparam int CHW   = 2 + CH_W;
  localparam int TRW   = 2 + LOST_W;
  localparam int SW    = imax(HDR_W, imax(CHW, TRW));
  localparam int CW    = $clog2(SW + 1);

  rd_state_e         state;
  logic [NCH-1:0]    snap;
  logic [SW-1:0]     sh;
  logic [CW-1:0]     cnt;
  logic              in_trl;
  logic [EV_W-1:0]   ev_ctr;
  logic [LOST_W-1:0] lost_ctr;
  logic [EV_W-1:0]   act_ev;
  logic [TIME_W-1:0] act_t;
  logic [LOST_W-1:0] act_lost;
  logic              pend_v;
  logic              pend_load;
  logic [NCH-1:0]    pend_snap;
  logic [EV_W-1:0]   pend_ev;
  logic [TIME_W-1:0] pend_t;
  logic [LOST_W-1:0] pend_lost;

  logic [CH_W-1:0] low_idx;
  logic            any_hit;
  logic            can_start, slot_free;
  logic            accept_new, accept_pend, lose;

  ltb_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan (
    .vec(snap), .low_idx(low_idx), .any(any_hit)
  );

  function automatic logic [SW-1:0] lalign(input logic [SW-1:0] v, input int w);
    return v << (SW - w);
  endfunction

  always_comb begin
    can_start   = (state == S_IDLE) || ((state == S_DONE) && !pend_v);
    slot_free   = !pend_v || (state == S_DONE);
    accept_new  = trig && can_start;
    accept_pend = trig && !can_start && slot_free;
    lose        = trig && !accept_new && !accept_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      snap      <= '0;
      sh        <= '0;
      cnt       <= '0;
      in_trl    <= 1'b0;
      ev_ctr    <= '0;
      lost_ctr  <= '0;
      act_ev    <= '0;
      act_t     <= '0;
      act_lost  <= '0;
      pend_v    <= 1'b0;
      pend_load <= 1'b0;
      pend_snap <= '0;
      pend_ev   <= '0;
      pend_t    <= '0;
      pend_lost <= '0;
      sdo       <= 1'b0;
      sval      <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (accept_new || accept_pend) ev_ctr <= ev_ctr + 1'b1;
      if (lose && (lost_ctr != '1))  lost_ctr <= lost_ctr + 1'b1;
      pend_load <= 1'b0;
      if (pend_load) pend_snap <= rd_data;

      case (state)
        S_IDLE: begin
          sval <= 1'b0;
          sdo  <= 1'b0;
          busy <= accept_new;
          if (accept_new) begin
            state    <= S_LOAD;
            act_ev   <= ev_ctr;
            act_t    <= tstamp;
            act_lost <= lost_ctr;
          end
        end
        S_LOAD: begin
          snap   <= rd_data;
          sh     <= lalign(SW'({MK_HDR, act_ev, act_t}), HDR_W);
          cnt    <= CW'(HDR_W);
          in_trl <= 1'b0;
          busy   <= 1'b1;
          state  <= S_SEND;
        end
        S_SEND: begin
          sdo  <= sh[SW-1];
          sval <= 1'b1;
          busy <= 1'b1;
          if (cnt == CW'(1)) begin
            if (in_trl) begin
              state <= S_DONE;
            end else if (any_hit) begin
              sh            <= lalign(SW'({MK_CH, low_idx}), CHW);
              cnt           <= CW'(CHW);
              snap[low_idx] <= 1'b0;
            end else begin
              sh     <= lalign(SW'({MK_TRL, act_lost}), TRW);
              cnt    <= CW'(TRW);
              in_trl <= 1'b1;
            end
          end else begin
            sh  <= sh << 1;
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          sval <= 1'b0;
          sdo  <= 1'b0;
          busy <= pend_v || accept_new;
          if (pend_v) begin
            snap     <= pend_load ? rd_data : pend_snap;
            act_lost <= pend_lost;
            sh       <= lalign(SW'({MK_HDR, pend_ev, pend_t}), HDR_W);
            cnt      <= CW'(HDR_W);
            in_trl   <= 1'b0;
            pend_v   <= 1'b0;
            state    <= S_SEND;
          end else if (accept_new) begin
            act_ev   <= ev_ctr;
            act_t    <= tstamp;
            act_lost <= lost_ctr;
            state    <= S_LOAD;
          end else begin
            state <= S_IDLE;
          end
        end
      endcase

      if (accept_pend) begin
        pend_v    <= 1'b1;
        pend_load <= 1'b1;
        pend_ev   <= ev_ctr;
        pend_t    <= tstamp;
        pend_lost <= lost_ctr;
      end
    end
  end
endmodule

// File: rtl/ltb_trigger_readout.sv
module ltb_trigger_readout #(
  parameter int NCH    = 128,
  parameter int DEPTH  = 193,
  parameter int LAT_W  = 8,
  parameter int EV_W   = 8,
  parameter int TIME_W = 8,
  parameter int LOST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   hit,
  input  logic             trig,
  input  logic [LAT_W-1:0] lat,
  output logic             sdo,
  output logic             sval,
  output logic             busy
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rd_addr;
  logic [NCH-1:0]    rd_data;
  logic [TIME_W-1:0] tstamp;

  always_ff @(posedge clk) begin
    if (rst) tstamp <= '0;
    else     tstamp <= tstamp + 1'b1;
  end

  ltb_ring #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW)) u_ring (
    .clk(clk), .rst(rst), .wr_hits(hit), .rd_addr(rd_addr),
    .rd_data(rd_data), .wptr(wptr)
  );

  ltb_rdaddr #(.DEPTH(DEPTH), .LAT_W(LAT_W), .AW(AW)) u_rdaddr (
    .wptr(wptr), .lat(lat), .rd_addr(rd_addr)
  );

  ltb_serial #(.NCH(NCH), .EV_W(EV_W), .TIME_W(TIME_W), .LOST_W(LOST_W)) u_serial (
    .clk(clk), .rst(rst), .trig(trig), .tstamp(tstamp), .rd_data(rd_data),
    .sdo(sdo), .sval(sval), .busy(busy)
  );
endmodule

// File: rtl/ltb_checker.sv
module ltb_checker #(
  parameter int DEPTH = 193,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          trig,
  input logic          sdo,
  input logic          sval,
  input logic          busy,
  input logic [AW-1:0] wptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r2_wptr_in_range: assert property (@(posedge clk) disable iff (rst)
    wptr <= LAST);

  a_r2_wptr_wraps: assert property (@(posedge clk) disable iff (rst)
    (wptr == LAST) |=> (wptr == '0));

  a_r2_wptr_steps: assert property (@(posedge clk) disable iff (rst)
    (wptr != LAST) |=> (wptr == AW'($past(wptr) + 1'b1)));

  a_r9_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    sval |-> busy);

  a_r9_busy_from_trigger: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig));

  a_r5_frame_opens_with_header: assert property (@(posedge clk) disable iff (rst)
    $rose(sval) |-> sdo);
endmodule

bind ltb_trigger_readout ltb_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .sdo(sdo), .sval(sval),
  .busy(busy), .wptr(wptr)
);

// File: tb/tb_ltb_trigger_readout.sv
module tb_ltb_trigger_readout;
  localparam int NCH = 128;
  localparam int DEPTH = 193;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] hit = '0;
  logic           trig = 1'b0;
  logic [7:0]     lat = 8'd1;
  logic           sdo, sval, busy;

  ltb_trigger_readout dut (
    .clk(clk), .rst(rst), .hit(hit), .trig(trig), .lat(lat),
    .sdo(sdo), .sval(sval), .busy(busy)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic [NCH-1:0] hist [256];
  int  ecount = 0;
  int  outstanding = 0;
  int  lost_m = 0;
  int  ev_m = 0;
  bit  expq[$];
  int  flen[$];

  // receiver state
  int  fbits = 0;
  int  frames = 0;
  int  last_len = 0;
  bit  ferr = 0;
  int  ferr_pos = 0;
  bit  ferr_got = 0, ferr_exp = 0;
  bit  prev_sval = 0;
  bit  prev_last = 0;
  int  gap_viol = 0;
  int  busy_viol = 0;
  int  extra_bits = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  function automatic int leff_of(input int l);
    if (l == 0) return 1;
    if (l > DEPTH - 1) return DEPTH - 1;
    return l;
  endfunction

  // model: runs on each active edge
  always @(posedge clk) begin
    if (!rst) begin
      if (trig) begin
        if (outstanding < 2) begin
          logic [NCH-1:0] hv;
          hv = hist[(ecount - leff_of(int'(lat))) % 256];
          expq.push_back(1'b1); expq.push_back(1'b0);
          for (int b = 7; b >= 0; b--) expq.push_back(ev_m[b]);
          for (int b = 7; b >= 0; b--) expq.push_back(ecount[b]);
          for (int c = 0; c < NCH; c++) begin
            if (hv[c]) begin
              expq.push_back(1'b0); expq.push_back(1'b1);
              for (int b = 6; b >= 0; b--) expq.push_back(c[b]);
            end
          end
          expq.push_back(1'b1); expq.push_back(1'b1);
          for (int b = 3; b >= 0; b--) expq.push_back(lost_m[b]);
          flen.push_back(24 + 9 * $countones(hv));
          ev_m = (ev_m + 1) % 256;
          outstanding++;
        end else if (lost_m < 15) begin
          lost_m++;
        end
      end
      hist[ecount % 256] = hit;
      ecount++;
    end
  end

  // receiver: samples away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sval && !busy) busy_viol++;
      if (sval && !prev_sval && prev_last) gap_viol++;
      prev_last = 0;
      if (sval && !prev_sval && prev_sval == 0 && fbits != 0) gap_viol++;
      if (sval) begin
        if (expq.size() == 0) begin
          extra_bits++;
        end else begin
          bit e;
          e = expq.pop_front();
          if (!ferr && e != sdo) begin
            ferr = 1; ferr_pos = fbits; ferr_got = sdo; ferr_exp = e;
          end
          fbits++;
          if (flen.size() > 0 && fbits == flen[0]) begin
            checks++;
            if (ferr) begin
              errors++;
              $display("FAIL R3 R4 R5 R6 R7 R8 R11 frame %0d bit %0d: actual %0b expected %0b",
                       frames, ferr_pos, ferr_got, ferr_exp);
            end
            last_len = fbits;
            void'(flen.pop_front());
            outstanding--;
            frames++;
            fbits = 0;
            ferr = 0;
            prev_last = 1;
          end
        end
      end else if (fbits != 0) begin
        gap_viol++;
      end
      prev_sval = sval;
    end
  end

  function automatic logic [NCH-1:0] rnd_hits(input int dens);
    logic [NCH-1:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    for (int k = 0; k < dens; k++) v &= {$urandom, $urandom, $urandom, $urandom};
    return v;
  endfunction

  task automatic step(input logic [NCH-1:0] h, input logic t, input logic [7:0] l);
    @(negedge clk);
    #1;
    hit = h; trig = t; lat = l;
  endtask

  task automatic drain();
    int quiet = 0;
    for (int k = 0; k < 20000 && quiet < 4; k++) begin
      step(rnd_hits(3), 1'b0, lat);
      if (!busy && !sval) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sdo == 1'b0, "R1 sdo in reset", int'(sdo), 0);
    chk(sval == 1'b0, "R1 sval in reset", int'(sval), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!sval && !busy, "R1 outputs after reset", int'({sval, busy}), 0);

    // fill the whole history (R2 wrap needed before any look-back)
    repeat (200) step(rnd_hits(3), 1'b0, 8'd1);

    // R3 R4: single trigger, sparse hits
    step(rnd_hits(3), 1'b1, 8'd5);
    drain();
    chk(frames == 1, "R3 R4 one frame", frames, 1);

    // R11: empty event
    repeat (30) step('0, 1'b0, 8'd10);
    step('0, 1'b1, 8'd10);
    drain();
    chk(last_len == 24, "R11 empty frame length", last_len, 24);

    // R3: latency clamps and oldest bin
    step(rnd_hits(2), 1'b1, 8'd0);   drain();
    step(rnd_hits(2), 1'b1, 8'd255); drain();
    step(rnd_hits(2), 1'b1, 8'd192); drain();
    step(rnd_hits(2), 1'b1, 8'd193); drain();
    step(rnd_hits(2), 1'b1, 8'd1);   drain();
    chk(frames == 7, "R3 clamp frames", frames, 7);

    // R4: every channel hit
    repeat (8) step('1, 1'b0, 8'd4);
    step('1, 1'b1, 8'd4);
    drain();
    chk(last_len == 24 + 9 * NCH, "R4 full frame length", last_len, 24 + 9 * NCH);

    // R10 R6 R7: burst of four triggers, two accepted, two lost
    begin
      int f0;
      f0 = frames;
      for (int k = 0; k < 4; k++) step(rnd_hits(3), 1'b1, 8'd20);
      drain();
      chk(frames - f0 == 2, "R10 queued depth one", frames - f0, 2);
      step(rnd_hits(3), 1'b1, 8'd7);
      drain();
      chk(lost_m == 2, "R7 R10 lost count", lost_m, 2);
    end

    // random traffic with mixed density and latency
    for (int it = 0; it < 6000; it++) begin
      logic t;
      t = ($urandom % 60) == 0;
      if (($urandom % 400) == 0) begin
        for (int k = 0; k < 3; k++) step(rnd_hits(3), 1'b1, 8'($urandom));
      end else begin
        step(rnd_hits(1 + ($urandom % 4)), t, 8'($urandom));
      end
    end
    drain();

    chk(expq.size() == 0, "R8 R10 all expected bits seen", expq.size(), 0);
    chk(outstanding == 0, "R10 no frame outstanding", outstanding, 0);
    chk(extra_bits == 0, "R8 no unexpected bits", extra_bits, 0);
    chk(gap_viol == 0, "R8 frame gaps", gap_viol, 0);
    chk(busy_viol == 0, "R9 busy covers valid", busy_viol, 0);
    chk(lost_m == 15, "R7 lost count saturation", lost_m, 15);
    chk(busy == 1'b0, "R9 busy low at end", int'(busy), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule